// File: doc/BRIEF.md
# PC-Relative Register-Pair Load Unit

This unit carries out a load of two consecutive 32-bit words from an address formed relative to the program counter, and hands the two words to a register-pair write path. It takes one 32-bit instruction word together with a select that names the encoding in use. The classic encoding is word-aligned and carries a split byte offset with an implied second register. The compact encoding carries a word-scaled offset and two independent register fields. The unit also takes the current PC, a condition-passed flag from upstream condition evaluation, and the data endianness. Opcode bits outside the fields named below are assumed to be checked by an upstream decoder.

The effective address is the PC with its two low bits cleared, plus or minus a zero-extended immediate. When that address sits on an 8-byte boundary, one 64-bit read is issued and split into the two words according to endianness. Otherwise the unit issues two 32-bit reads in sequence, at the address and at the address plus 4. Illegal register choices raise an undefined-instruction flag with no memory traffic. A failed condition retires the instruction at once as a no-op. The unit takes one instruction at a time and signals completion with a single done pulse that coincides with both register writes.

Top module: `pcrel_pair_load`

## Requirements
- R1: The address is {pcValue[31:2],2'b00} plus the immediate when instWord[23] is 1 and minus it when instWord[23] is 0. The arithmetic is 32-bit and wraps, so subtracting a zero immediate gives the same address as adding zero.
- R2: When compactEnc is 0, the first register is instWord[15:12], the second register is the first plus one, and the immediate is the byte value {instWord[11:8],instWord[3:0]}.
- R3: When compactEnc is 1, the first register is instWord[15:12], the second is instWord[11:8], and the immediate is instWord[7:0] times 4. The P bit is instWord[24] and the W bit is instWord[21].
- R4: If address bits [2:0] are zero, exactly one request is issued, with memReqWide=1 at that address.
- R5: For a wide read with bigEndian=0, port A gets memRspData[31:0] and port B gets memRspData[63:32]. With bigEndian=1 the two halves are swapped.
- R6: If the address is not 8-byte aligned, two requests with memReqWide=0 are issued, at the address and then at the address plus 4. Port A gets the first response and port B the second, taken from memRspData[31:0] in each case and independent of bigEndian.
- R7: In the classic encoding, an odd first register or a first register of 14 (second equal to 15) raises undefInst together with done. No request is issued and no register is written.
- R8: In the compact encoding, either register equal to 15, both registers equal, W=1, or P=0 with W=0 raises undefInst together with done. No request is issued and no register is written.
- R9: With condPass=0, done rises in the cycle after acceptance, with no request, no register write and no undefInst.
- R10: A request is held with a stable address and width until memReqReady. instReady is low while a request is outstanding. done and the writes appear one cycle after the final response is accepted.
- R11: wrEnA and wrEnB are asserted together, only with done, once per executed load, and with distinct register indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Unit idle, instruction accepted when valid |
| instWord | input | 32 | Instruction word |
| compactEnc | input | 1 | 1 selects the compact encoding, 0 the classic one |
| pcValue | input | 32 | PC of the instruction |
| condPass | input | 1 | Condition check result |
| bigEndian | input | 1 | Data endianness for wide reads |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | 32 | Request byte address |
| memReqWide | output | 1 | 1 for a 64-bit read, 0 for a 32-bit read |
| memRspValid | input | 1 | Read data strobe |
| memRspData | input | 64 | Read data; the low 32 bits for narrow reads |
| wrEnA | output | 1 | First register write enable |
| wrIdxA | output | 4 | First register index |
| wrDataA | output | 32 | First register data |
| wrEnB | output | 1 | Second register write enable |
| wrIdxB | output | 4 | Second register index |
| wrDataB | output | 32 | Second register data |
| done | output | 1 | Instruction retired |
| undefInst | output | 1 | Illegal encoding, raised with done |

## Verification
The bench builds the unit with its package defaults: 32-bit addresses and words, 4-bit register indices and an 8-bit immediate field. These defaults reach every address corner that matters here: wrap past zero in both directions, an 8-byte boundary landing exactly on the second half of a split access, and the largest compact offset of 1020. A bench-side memory stalls its ready for several cycles on some tests, so the hold and busy rules are exercised. It also puts junk in the upper half of narrow responses, so that a leak from that half would be seen.

// File: rtl/pairload_pkg.sv
package pairload_pkg;
  localparam int ADDR_W   = 32;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 4;
  localparam int IMM_W    = 8;
  localparam int DWORD_W  = 2 * WORD_W;
  localparam int BEAT_B   = WORD_W / 8;
  localparam int WIDE_LSB = $clog2(2 * BEAT_B);
  localparam int WORD_LSB = $clog2(BEAT_B);

  typedef struct packed {
    logic latchInst;
    logic bumpAddr;
    logic captureLow;
    logic commitWide;
    logic commitSplit;
    logic retireNop;
    logic retireUndef;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ctrlState_t;
endpackage

// File: rtl/pairload_ctrl.sv
module pairload_ctrl
  import pairload_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instValid,
  input  logic         condPass,
  input  logic         illegalDec,
  input  logic         wideSel,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output logic         instReady,
  output logic         memReqValid,
  output ctrlStrobes_t strobes
);
  ctrlState_t stateQ, stateD;
  logic secondQ, secondD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      secondQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      secondQ <= secondD;
    end
  end

  always_comb begin
    stateD      = stateQ;
    secondD     = secondQ;
    strobes     = '0;
    instReady   = (stateQ == ST_IDLE);
    memReqValid = (stateQ == ST_REQ);
    unique case (stateQ)
      ST_IDLE: begin
        if (instValid) begin
          if (!condPass) begin
            strobes.retireNop = 1'b1;
          end else if (illegalDec) begin
            strobes.retireUndef = 1'b1;
          end else begin
            strobes.latchInst = 1'b1;
            secondD = 1'b0;
            stateD  = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (memReqReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (wideSel) begin
            strobes.commitWide = 1'b1;
            stateD = ST_IDLE;
          end else if (!secondQ) begin
            strobes.captureLow = 1'b1;
            strobes.bumpAddr   = 1'b1;
            secondD = 1'b1;
            stateD  = ST_REQ;
          end else begin
            strobes.commitSplit = 1'b1;
            secondD = 1'b0;
            stateD  = ST_IDLE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pairload_dp.sv
module pairload_dp
  import pairload_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [31:0]        instWord,
  input  logic               compactEnc,
  input  logic [ADDR_W-1:0]  pcValue,
  input  logic               bigEndian,
  input  logic [DWORD_W-1:0] memRspData,
  output logic               illegalDec,
  output logic               wideSel,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic               wrEn,
  output logic [IDX_W-1:0]   wrIdxA,
  output logic [WORD_W-1:0]  wrDataA,
  output logic [IDX_W-1:0]   wrIdxB,
  output logic [WORD_W-1:0]  wrDataB,
  output logic               doneQ,
  output logic               undefQ
);
  localparam logic [IDX_W-1:0] PC_IDX = '1;

  logic               upBit, preBit, wbBit;
  logic [IDX_W-1:0]   rtD, rt2D;
  logic [ADDR_W-1:0]  immD, baseD, addrD;

  logic [ADDR_W-1:0]  addrQ;
  logic [IDX_W-1:0]   rtQ, rt2Q;
  logic               wideQ, beQ;
  logic [WORD_W-1:0]  lowQ;

  always_comb begin
    upBit  = instWord[23];
    preBit = instWord[24];
    wbBit  = instWord[21];
    rtD    = instWord[15:12];
    if (compactEnc) begin
      rt2D       = instWord[11:8];
      immD       = ADDR_W'({instWord[IMM_W-1:0], 2'b00});
      illegalDec = (rtD == PC_IDX) || (rt2D == PC_IDX) || (rtD == rt2D)
                   || wbBit || !preBit;
    end else begin
      rt2D       = rtD + 1'b1;
      immD       = ADDR_W'({instWord[11:8], instWord[3:0]});
      illegalDec = rtD[0] || (rt2D == PC_IDX);
    end
    baseD = {pcValue[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
    addrD = upBit ? (baseD + immD) : (baseD - immD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      rtQ   <= '0;
      rt2Q  <= '0;
      wideQ <= 1'b0;
      beQ   <= 1'b0;
      lowQ  <= '0;
    end else begin
      if (strobes.latchInst) begin
        addrQ <= addrD;
        rtQ   <= rtD;
        rt2Q  <= rt2D;
        wideQ <= (addrD[WIDE_LSB-1:0] == '0);
        beQ   <= bigEndian;
      end else if (strobes.bumpAddr) begin
        addrQ <= addrQ + ADDR_W'(BEAT_B);
      end
      if (strobes.captureLow) lowQ <= memRspData[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEn    <= 1'b0;
      doneQ   <= 1'b0;
      undefQ  <= 1'b0;
      wrIdxA  <= '0;
      wrIdxB  <= '0;
      wrDataA <= '0;
      wrDataB <= '0;
    end else begin
      wrEn   <= strobes.commitWide | strobes.commitSplit;
      doneQ  <= strobes.commitWide | strobes.commitSplit
              | strobes.retireNop | strobes.retireUndef;
      undefQ <= strobes.retireUndef;
      if (strobes.commitWide) begin
        wrIdxA  <= rtQ;
        wrIdxB  <= rt2Q;
        wrDataA <= beQ ? memRspData[DWORD_W-1:WORD_W] : memRspData[WORD_W-1:0];
        wrDataB <= beQ ? memRspData[WORD_W-1:0] : memRspData[DWORD_W-1:WORD_W];
      end else if (strobes.commitSplit) begin
        wrIdxA  <= rtQ;
        wrIdxB  <= rt2Q;
        wrDataA <= lowQ;
        wrDataB <= memRspData[WORD_W-1:0];
      end
    end
  end

  assign wideSel    = wideQ;
  assign memReqAddr = addrQ;
endmodule

// File: rtl/pcrel_pair_load.sv
module pcrel_pair_load
  import pairload_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instValid,
  output logic               instReady,
  input  logic [31:0]        instWord,
  input  logic               compactEnc,
  input  logic [ADDR_W-1:0]  pcValue,
  input  logic               condPass,
  input  logic               bigEndian,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic               memReqWide,
  input  logic               memRspValid,
  input  logic [DWORD_W-1:0] memRspData,
  output logic               wrEnA,
  output logic [IDX_W-1:0]   wrIdxA,
  output logic [WORD_W-1:0]  wrDataA,
  output logic               wrEnB,
  output logic [IDX_W-1:0]   wrIdxB,
  output logic [WORD_W-1:0]  wrDataB,
  output logic               done,
  output logic               undefInst
);
  ctrlStrobes_t strobes;
  logic illegalDec, wideSel, wrEn;

  pairload_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .condPass(condPass),
    .illegalDec(illegalDec), .wideSel(wideSel), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .instReady(instReady),
    .memReqValid(memReqValid), .strobes(strobes)
  );

  pairload_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .instWord(instWord),
    .compactEnc(compactEnc), .pcValue(pcValue), .bigEndian(bigEndian),
    .memRspData(memRspData), .illegalDec(illegalDec), .wideSel(wideSel),
    .memReqAddr(memReqAddr), .wrEn(wrEn), .wrIdxA(wrIdxA),
    .wrDataA(wrDataA), .wrIdxB(wrIdxB), .wrDataB(wrDataB),
    .doneQ(done), .undefQ(undefInst)
  );

  assign memReqWide = wideSel;
  assign wrEnA      = wrEn;
  assign wrEnB      = wrEn;
endmodule

// File: rtl/pairload_chk.sv
module pairload_chk
  import pairload_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memReqWide,
  input logic              wrEnA,
  input logic              wrEnB,
  input logic [IDX_W-1:0]  wrIdxA,
  input logic [IDX_W-1:0]  wrIdxB,
  input logic              done,
  input logic              undefInst
);
  p_wide_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && memReqWide) |-> (memReqAddr[WIDE_LSB-1:0] == '0));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWide)));

  p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> !instReady);

  p_write_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEnA || wrEnB) |-> (done && wrEnA && wrEnB));

  p_pair_distinct_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wrEnA |-> (wrIdxA != wrIdxB));

  p_undef_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    undefInst |-> (done && !wrEnA));
endmodule

bind pcrel_pair_load pairload_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instReady(instReady), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memReqWide(memReqWide),
  .wrEnA(wrEnA), .wrEnB(wrEnB), .wrIdxA(wrIdxA), .wrIdxB(wrIdxB),
  .done(done), .undefInst(undefInst)
);

// File: tb/tb_pcrel_pair_load.sv
module tb_pcrel_pair_load;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instValid = 1'b0, instReady;
  logic [31:0] instWord = '0;
  logic compactEnc = 1'b0, condPass = 1'b1, bigEndian = 1'b0;
  logic [31:0] pcValue = '0;
  logic memReqValid, memReqWide;
  logic memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic wrEnA, wrEnB, done, undefInst;
  logic [3:0] wrIdxA, wrIdxB;
  logic [31:0] wrDataA, wrDataB;

  pcrel_pair_load dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int reqN = 0, stallSet = 0, stallLeft = 0, rspDelay = 0, rspCyc = 0;
  int doneCnt = 0, doneCyc = 0, strayWr = 0, busyReady = 0;
  logic [31:0] reqAddr [4];
  logic reqWide [4];
  logic [31:0] pendAddr = '0;
  logic pendWide = 1'b0;
  logic gotWr, gotUndef;
  logic [3:0] gotIdxA, gotIdxB;
  logic [31:0] gotA, gotB;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return ~a ^ {a[15:0], a[31:16]} ^ 32'h3C3C_0000;
  endfunction

  function automatic logic [31:0] mkClassic(input logic u, input logic [3:0] rt,
                                            input logic [7:0] imm);
    return {4'hE, 3'b000, 1'b1, u, 1'b1, 1'b0, 1'b0, 4'hF, rt, imm[7:4], 4'b1101, imm[3:0]};
  endfunction

  function automatic logic [31:0] mkCompact(input logic p, input logic u, input logic w,
                                            input logic [3:0] rt, input logic [3:0] rt2,
                                            input logic [7:0] imm);
    return {7'b1110100, p, u, 1'b1, w, 1'b1, 4'hF, rt, rt2, imm};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory model and monitor, sampled away from the active edge
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rspDelay > 0) begin
      rspDelay--;
      if (rspDelay == 0) begin
        memRspValid = 1'b1;
        rspCyc = cyc;
        memRspData = pendWide ? {memWord(pendAddr + 32'd4), memWord(pendAddr)}
                              : {32'hDEAD_BEEF, memWord(pendAddr)};
      end
    end
    memReqReady = 1'b0;
    if (memReqValid) begin
      if (instReady) busyReady++;
      if (stallLeft > 0) stallLeft--;
      else begin
        memReqReady = 1'b1;
        if (reqN < 4) begin
          reqAddr[reqN] = memReqAddr;
          reqWide[reqN] = memReqWide;
        end
        reqN++;
        pendAddr = memReqAddr;
        pendWide = memReqWide;
        rspDelay = 2;
        stallLeft = stallSet;
      end
    end
    if (wrEnA && !done) strayWr++;
    if (done) begin
      doneCnt++;
      doneCyc = cyc;
      gotWr = wrEnA && wrEnB;
      gotUndef = undefInst;
      gotIdxA = wrIdxA; gotIdxB = wrIdxB;
      gotA = wrDataA; gotB = wrDataB;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic cmp, input logic [31:0] pc,
                       input logic cp, input logic be, output int accCyc);
    int startDone;
    @(negedge clk);
    reqN = 0;
    stallLeft = stallSet;
    startDone = doneCnt;
    instWord = w; compactEnc = cmp; pcValue = pc; condPass = cp; bigEndian = be;
    instValid = 1'b1;
    accCyc = cyc + 1;
    @(negedge clk);
    instValid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      #1;
      if (doneCnt > startDone) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(doneCnt == startDone + 1, "R11 one done per instruction", 64'(doneCnt - startDone), 64'd1);
    check(strayWr == 0, "R11 write without done", 64'(strayWr), 64'd0);
  endtask

  task automatic runLoad(input string tag, input logic [31:0] w, input logic cmp,
                         input logic [31:0] pc, input logic be, input logic [31:0] addr,
                         input logic [3:0] ia, input logic [3:0] ib);
    int acc;
    logic wide;
    logic [31:0] ea, eb;
    wide = (addr[2:0] == 3'b000);
    issue(w, cmp, pc, 1'b1, be, acc);
    check(!gotUndef && gotWr, {tag, " write enables"}, {62'd0, gotUndef, gotWr}, 64'd1);
    check(gotIdxA == ia && gotIdxB == ib, {tag, " R2/R3 indices"},
          {56'd0, gotIdxA, gotIdxB}, {56'd0, ia, ib});
    check(doneCyc == rspCyc + 1, {tag, " R10 done latency"}, 64'(doneCyc), 64'(rspCyc + 1));
    if (wide) begin
      check(reqN == 1 && reqWide[0] && reqAddr[0] == addr, {tag, " R4/R1 wide request"},
            {reqN[30:0], reqWide[0], reqAddr[0]}, {31'd1, 1'b1, addr});
      ea = be ? memWord(addr + 32'd4) : memWord(addr);
      eb = be ? memWord(addr) : memWord(addr + 32'd4);
      check(gotA == ea && gotB == eb, {tag, " R5 split by endianness"}, {gotA, gotB}, {ea, eb});
    end else begin
      check(reqN == 2 && !reqWide[0] && !reqWide[1] && reqAddr[0] == addr &&
            reqAddr[1] == addr + 32'd4, {tag, " R6/R1 two narrow requests"},
            {reqAddr[0], reqAddr[1]}, {addr, addr + 32'd4});
      ea = memWord(addr);
      eb = memWord(addr + 32'd4);
      check(gotA == ea && gotB == eb, {tag, " R6 data order"}, {gotA, gotB}, {ea, eb});
    end
  endtask

  task automatic runIllegal(input string tag, input logic [31:0] w, input logic cmp);
    int acc;
    issue(w, cmp, 32'h0000_1000, 1'b1, 1'b0, acc);
    check(gotUndef && !gotWr && reqN == 0, {tag, " undefined, silent"},
          {gotUndef, gotWr, reqN[29:0]}, {1'b1, 1'b0, 30'd0});
  endtask

  task automatic testReset();
    check(!done && !wrEnA && !memReqValid && instReady && !undefInst, "R10 reset state",
          {59'd0, done, wrEnA, memReqValid, instReady, undefInst}, 64'b00010);
  endtask

  task automatic testClassicWide();
    runLoad("R2 classic LE", mkClassic(1'b1, 4'd4, 8'h18), 1'b0, 32'h0000_1000, 1'b0,
            32'h0000_1018, 4'd4, 4'd5);
    runLoad("R5 classic BE", mkClassic(1'b1, 4'd4, 8'h18), 1'b0, 32'h0000_1002, 1'b1,
            32'h0000_1018, 4'd4, 4'd5);
  endtask

  task automatic testClassicSplitStall();
    stallSet = 3;
    runLoad("R6 classic split stalled", mkClassic(1'b0, 4'd8, 8'h13), 1'b0, 32'h0000_2003,
            1'b1, 32'h0000_1FED, 4'd8, 4'd9);
    check(busyReady == 0, "R10 instReady low while busy", 64'(busyReady), 64'd0);
    stallSet = 0;
  endtask

  task automatic testCompact();
    runLoad("R3 compact max offset", mkCompact(1'b1, 1'b1, 1'b0, 4'd2, 4'd9, 8'hFF), 1'b1,
            32'h0000_3002, 1'b0, 32'h0000_33FC, 4'd2, 4'd9);
    runLoad("R3 compact wide subtract", mkCompact(1'b1, 1'b0, 1'b0, 4'd0, 4'd14, 8'h02), 1'b1,
            32'h0000_4000, 1'b1, 32'h0000_3FF8, 4'd0, 4'd14);
  endtask

  task automatic testWrapAndZero();
    runLoad("R1 wrap below zero", mkClassic(1'b0, 4'd6, 8'h10), 1'b0, 32'h0000_0004, 1'b0,
            32'hFFFF_FFF4, 4'd6, 4'd7);
    runLoad("R1 wrap above top", mkClassic(1'b1, 4'd10, 8'h0C), 1'b0, 32'hFFFF_FFFF, 1'b0,
            32'h0000_0008, 4'd10, 4'd11);
    runLoad("R1 minus zero", mkClassic(1'b0, 4'd12, 8'h00), 1'b0, 32'h0000_5006, 1'b0,
            32'h0000_5004, 4'd12, 4'd13);
    runLoad("R1 plus zero", mkClassic(1'b1, 4'd12, 8'h00), 1'b0, 32'h0000_5006, 1'b0,
            32'h0000_5004, 4'd12, 4'd13);
  endtask

  task automatic testIllegal();
    runIllegal("R7 classic odd first", mkClassic(1'b1, 4'd3, 8'h08), 1'b0);
    runIllegal("R7 classic first 14", mkClassic(1'b1, 4'd14, 8'h08), 1'b0);
    runIllegal("R8 compact first 15", mkCompact(1'b1, 1'b1, 1'b0, 4'd15, 4'd2, 8'h01), 1'b1);
    runIllegal("R8 compact second 15", mkCompact(1'b1, 1'b1, 1'b0, 4'd2, 4'd15, 8'h01), 1'b1);
    runIllegal("R8 compact same regs", mkCompact(1'b1, 1'b1, 1'b0, 4'd5, 4'd5, 8'h01), 1'b1);
    runIllegal("R8 compact writeback", mkCompact(1'b1, 1'b1, 1'b1, 4'd2, 4'd3, 8'h01), 1'b1);
    runIllegal("R8 compact P0 W0", mkCompact(1'b0, 1'b1, 1'b0, 4'd2, 4'd3, 8'h01), 1'b1);
  endtask

  task automatic testCondFail();
    int acc;
    issue(mkClassic(1'b1, 4'd4, 8'h18), 1'b0, 32'h0000_1000, 1'b0, 1'b0, acc);
    check(!gotUndef && !gotWr && reqN == 0, "R9 no-op on failed condition",
          {gotUndef, gotWr, reqN[29:0]}, 64'd0);
    check(doneCyc == acc, "R9 done one cycle after accept", 64'(doneCyc), 64'(acc));
    issue(mkClassic(1'b1, 4'd3, 8'h18), 1'b0, 32'h0000_1000, 1'b0, 1'b0, acc);
    check(!gotUndef && reqN == 0, "R9 failed condition masks illegal",
          {gotUndef, reqN[30:0]}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testClassicWide();
    testClassicSplitStall();
    testCompact();
    testWrapAndZero();
    testIllegal();
    testCondFail();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule